// File: doc/BRIEF.md
# Event Data Buffer Controller

This block buffers front-end event data for several parallel channels. Each channel owns a 32-bit data FIFO and a companion FIFO that records the word count of every finished event. A per-channel state machine moves through three phases. It idles until a trigger arrives, then accepts data words on a write strobe. When the channel's finished strobe closes the event, it waits for the busy release.

The busy release toward the trigger source comes from one of two policies, chosen by a parameter. The first lets it follow the user release inputs as soon as a trigger is pending. The second also holds it until every channel has closed its event. A readout sequencer drains one event at a time. It visits the channels from the lowest index upward and emits each channel's words, skipping channels whose event is empty. A 32-bit status word per channel reports fill level, flags and phase, and is selected by a 16-bit status address.

Top module: `evt_buf_ctrl`

## Requirements
- R1: After reset, busy_release_o, afull_o, ovf_o and rd_valid_o are 0. Every channel's status word reads 0x0111_0000, which means fill 0, data empty (bit 16), phase idle (bit 20) and length FIFO empty (bit 24).
- R2: A trigger on trg_i moves all channels to the writing phase (status bit 21) only if all channels are idle and no release is pending. A trigger at any other time is ignored.
- R3: A data word is stored only while its channel is in the writing phase with wr_en_i high. Words offered at other times leave the fill level (status bits 15:0) unchanged. Status bit 19 is high in a cycle in which a word is stored.
- R4: A finished strobe in the writing phase pushes the event's stored word count, including a word stored in the same cycle, into the length FIFO. Status bit 27 is high in that cycle. The channel then enters the await-release phase (status bit 22).
- R5: A write offered while the data FIFO holds 2^DATA_DEPTH_LOG2 words is dropped and not counted. It sets that channel's ovf_o, which stays set until reset. Status bit 18 shows the data FIFO full.
- R6: afull_o and status bit 17 are high while the data fill level is at least DATA_AFULL_THR. Writes are still accepted up to the full depth, so the current event can complete.
- R7: With REL_AFTER_DATA=0, busy_release_o pulses high for exactly one cycle, one clock after all usr_rel_i bits are high while a trigger is pending, whether or not data is finished.
- R8: With REL_AFTER_DATA=1, busy_release_o pulses only once every channel is in the await-release phase and all usr_rel_i bits are high. Unused channels hold usr_rel_i at 1.
- R9: A channel in the await-release phase returns to idle once the release has been issued.
- R10: A pulse on rd_start_i, given when the sequencer is idle and every length FIFO holds an entry, reads one event. Channels are read in ascending index order. Each channel's words come out oldest first with rd_valid_o, and rd_ch_o gives the channel index. A zero-length channel is skipped, and rd_done_o pulses after the last channel.
- R11: stat_data_o returns channel c's status word when stat_addr_i equals STAT_BASE+c (0x7100+c by default) and 0 for any other address. Status bits 23 and 31:28 are 0.
- R12: Length FIFO status: bit 25 is high while its fill is at least LEN_AFULL_THR, and bit 26 is high while it holds 2^LEN_DEPTH_LOG2 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trg_i | input | 1 | Trigger pulse |
| wr_en_i | input | NUM_CH | Per-channel data write strobe |
| wr_data_i | input | 32*NUM_CH | Per-channel data word, channel c at bits 32c+31:32c |
| done_i | input | NUM_CH | Per-channel event finished strobe |
| usr_rel_i | input | NUM_CH | Per-channel user release, held at 1 when unused |
| rd_start_i | input | 1 | Start readout of one event |
| stat_addr_i | input | 16 | Status word select address |
| busy_release_o | output | 1 | One-cycle busy release pulse |
| afull_o | output | NUM_CH | Data FIFO almost full |
| ovf_o | output | NUM_CH | Sticky write-dropped flag |
| rd_valid_o | output | 1 | Readout word valid |
| rd_data_o | output | 32 | Readout word |
| rd_ch_o | output | CH_W | Channel of the readout word |
| rd_done_o | output | 1 | Readout of one event complete |
| stat_data_o | output | 32 | Selected status word |

## Verification
The main instance has three channels, a 256-word data FIFO with an almost-full threshold of 200, and a four-entry length FIFO with a threshold of 3. This lets the bench drive the data FIFO to full and beyond within a few hundred cycles. It also lets four empty events fill the length FIFO to its almost-full and full points. The instance releases after data, and an odd channel count exercises the channel index decode away from a power of two. A second two-channel instance uses the immediate release policy, so the bench can issue a release while data is still being written and see the late finish return the channel to idle.

// File: rtl/evt_buf_pkg.sv
package evt_buf_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_WRITE = 2'd1,
    CH_WAIT  = 2'd2
  } ch_state_e;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_LEN  = 2'd1,
    RD_DATA = 2'd2
  } rd_state_e;

  localparam int unsigned WORD_W = 32;

  function automatic logic [31:0] pack_status(
    input logic [15:0] fill,
    input logic        empty,
    input logic        afull,
    input logic        full,
    input logic        wr_stb,
    input ch_state_e   st,
    input logic        len_empty,
    input logic        len_afull,
    input logic        len_full,
    input logic        len_wr_stb
  );
    return {4'b0000, len_wr_stb, len_full, len_afull, len_empty,
            1'b0, st == CH_WAIT, st == CH_WRITE, st == CH_IDLE,
            wr_stb, full, afull, empty, fill};
  endfunction

endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int unsigned W         = 32,
  parameter int unsigned ALOG2     = 8,
  parameter int unsigned AFULL_THR = 200,
  localparam int unsigned DEPTH    = 1 << ALOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [ALOG2:0]   fill_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             afull_o
);

  logic [W-1:0]     mem [DEPTH];
  logic [ALOG2-1:0] wptr_q, rptr_q;
  logic [ALOG2:0]   cnt_q;
  logic             wr_ok, rd_ok;

  assign full_o  = (cnt_q == (ALOG2+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign afull_o = (32'(cnt_q) >= AFULL_THR);
  assign fill_o  = cnt_q;
  assign dout_o  = mem[rptr_q];
  assign wr_ok   = push_i && !full_o;
  assign rd_ok   = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + ALOG2'(1);
      if (rd_ok) rptr_q <= rptr_q + ALOG2'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + (ALOG2+1)'(1);
        2'b01:   cnt_q <= cnt_q - (ALOG2+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5: a push into a full FIFO without a pop leaves it full and unchanged
  a_r5_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && fill_o == $past(fill_o)));

  a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fill_o) <= DEPTH);

endmodule

// File: rtl/evt_chan.sv
module evt_chan import evt_buf_pkg::*; #(
  parameter int unsigned DLOG2   = 8,
  parameter int unsigned LLOG2   = 4,
  parameter int unsigned D_AFULL = 200,
  parameter int unsigned L_AFULL = 12,
  localparam int unsigned LEN_W   = DLOG2 + 1,
  localparam int unsigned L_DEPTH = 1 << LLOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trg_acc_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              done_i,
  input  logic              released_i,
  input  logic              data_pop_i,
  input  logic              len_pop_i,
  output logic [WORD_W-1:0] data_head_o,
  output logic [LEN_W-1:0]  len_head_o,
  output logic              len_empty_o,
  output ch_state_e         st_o,
  output logic              afull_o,
  output logic              ovf_o,
  output logic [31:0]       stat_o
);

  ch_state_e        st_q;
  logic [LEN_W-1:0] wcnt_q, len_din;
  logic             ovf_q;
  logic             in_write, wr_acc, wr_drop, len_push, len_wr;
  logic [DLOG2:0]   d_fill;
  logic [LLOG2:0]   l_fill;
  logic             d_empty, d_full, d_afull, l_empty, l_full, l_afull;

  assign in_write = (st_q == CH_WRITE);
  assign wr_acc   = in_write && wr_i && !d_full;
  assign wr_drop  = in_write && wr_i && d_full;
  assign len_push = in_write && done_i;
  assign len_wr   = len_push && !l_full;
  assign len_din  = wcnt_q + LEN_W'(wr_acc);

  evt_fifo #(.W(WORD_W), .ALOG2(DLOG2), .AFULL_THR(D_AFULL)) u_data (
    .clk_i, .rst_ni,
    .push_i(wr_acc), .din_i(din_i), .pop_i(data_pop_i),
    .dout_o(data_head_o), .fill_o(d_fill),
    .empty_o(d_empty), .full_o(d_full), .afull_o(d_afull)
  );

  evt_fifo #(.W(LEN_W), .ALOG2(LLOG2), .AFULL_THR(L_AFULL)) u_len (
    .clk_i, .rst_ni,
    .push_i(len_push), .din_i(len_din), .pop_i(len_pop_i),
    .dout_o(len_head_o), .fill_o(l_fill),
    .empty_o(l_empty), .full_o(l_full), .afull_o(l_afull)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CH_IDLE;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_drop) ovf_q <= 1'b1;
      case (st_q)
        CH_IDLE:  if (trg_acc_i) st_q <= CH_WRITE;
        CH_WRITE: begin
          if (done_i) begin
            st_q   <= CH_WAIT;
            wcnt_q <= '0;
          end else if (wr_acc) begin
            wcnt_q <= wcnt_q + LEN_W'(1);
          end
        end
        CH_WAIT:  if (released_i) st_q <= CH_IDLE;
        default:  st_q <= CH_IDLE;
      endcase
    end
  end

  assign st_o        = st_q;
  assign afull_o     = d_afull;
  assign ovf_o       = ovf_q;
  assign len_empty_o = l_empty;
  assign stat_o      = pack_status(16'(d_fill), d_empty, d_afull, d_full, wr_acc,
                                   st_q, l_empty, l_afull, l_full, len_wr);

  a_r4_done_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CH_WRITE && done_i) |=> (st_q == CH_WAIT));

  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  a_r3_no_write_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != CH_WRITE) |=> (d_fill <= $past(d_fill)));

  a_r12_len_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(l_fill) <= L_DEPTH);

endmodule

// File: rtl/evt_rd_seq.sv
module evt_rd_seq import evt_buf_pkg::*; #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned LEN_W  = 9,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [NUM_CH-1:0]              len_empty_i,
  input  logic [NUM_CH-1:0][LEN_W-1:0]   len_head_i,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  data_head_i,
  output logic [NUM_CH-1:0]              len_pop_o,
  output logic [NUM_CH-1:0]              data_pop_o,
  output logic                           rd_valid_o,
  output logic [WORD_W-1:0]              rd_data_o,
  output logic [CH_W-1:0]                rd_ch_o,
  output logic                           rd_done_o
);

  rd_state_e        st_q;
  logic [CH_W-1:0]  ch_q;
  logic [LEN_W-1:0] remain_q;
  logic             last_ch;

  assign last_ch = (ch_q == CH_W'(NUM_CH - 1));

  always_comb begin
    len_pop_o  = '0;
    data_pop_o = '0;
    if (st_q == RD_LEN)  len_pop_o[ch_q]  = 1'b1;
    if (st_q == RD_DATA) data_pop_o[ch_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RD_IDLE;
      ch_q       <= '0;
      remain_q   <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_ch_o    <= '0;
      rd_done_o  <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      rd_done_o  <= 1'b0;
      case (st_q)
        RD_IDLE: if (start_i && !(|len_empty_i)) begin
          st_q <= RD_LEN;
          ch_q <= '0;
        end
        RD_LEN: begin
          if (len_head_i[ch_q] == '0) begin
            // empty event on this channel: skip
            if (last_ch) begin
              st_q      <= RD_IDLE;
              rd_done_o <= 1'b1;
            end else begin
              ch_q <= ch_q + CH_W'(1);
            end
          end else begin
            remain_q <= len_head_i[ch_q];
            st_q     <= RD_DATA;
          end
        end
        RD_DATA: begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= data_head_i[ch_q];
          rd_ch_o    <= ch_q;
          remain_q   <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) begin
            if (last_ch) begin
              st_q      <= RD_IDLE;
              rd_done_o <= 1'b1;
            end else begin
              ch_q <= ch_q + CH_W'(1);
              st_q <= RD_LEN;
            end
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  a_r10_valid_from_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(st_q == RD_DATA));

  a_r10_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (rd_ch_o >= $past(rd_ch_o)));

endmodule

// File: rtl/evt_buf_ctrl.sv
module evt_buf_ctrl import evt_buf_pkg::*; #(
  parameter int unsigned NUM_CH          = 3,
  parameter int unsigned DATA_DEPTH_LOG2 = 8,
  parameter int unsigned LEN_DEPTH_LOG2  = 4,
  parameter int unsigned DATA_AFULL_THR  = 200,
  parameter int unsigned LEN_AFULL_THR   = 12,
  parameter bit          REL_AFTER_DATA  = 1'b1,
  parameter logic [15:0] STAT_BASE       = 16'h7100,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned LEN_W = DATA_DEPTH_LOG2 + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trg_i,
  input  logic [NUM_CH-1:0]        wr_en_i,
  input  logic [NUM_CH*WORD_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0]        done_i,
  input  logic [NUM_CH-1:0]        usr_rel_i,
  input  logic                     rd_start_i,
  input  logic [15:0]              stat_addr_i,
  output logic                     busy_release_o,
  output logic [NUM_CH-1:0]        afull_o,
  output logic [NUM_CH-1:0]        ovf_o,
  output logic                     rd_valid_o,
  output logic [WORD_W-1:0]        rd_data_o,
  output logic [CH_W-1:0]          rd_ch_o,
  output logic                     rd_done_o,
  output logic [31:0]              stat_data_o
);

  ch_state_e                      st [NUM_CH];
  logic [NUM_CH-1:0]              is_idle, is_wait, rel_cond;
  logic [NUM_CH-1:0]              len_empty, len_pop, data_pop;
  logic [NUM_CH-1:0][LEN_W-1:0]   len_head;
  logic [NUM_CH-1:0][WORD_W-1:0]  data_head;
  logic [NUM_CH-1:0][31:0]        stat;
  logic                           pend_q, trg_acc, rel_fire, released;

  assign trg_acc  = trg_i && (&is_idle) && !pend_q;
  assign rel_fire = pend_q && (&rel_cond);
  assign released = rel_fire || !pend_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign is_idle[c] = (st[c] == CH_IDLE);
    assign is_wait[c] = (st[c] == CH_WAIT);

    if (REL_AFTER_DATA) begin : g_after
      assign rel_cond[c] = usr_rel_i[c] && is_wait[c];
    end else begin : g_imm
      assign rel_cond[c] = usr_rel_i[c];
    end

    evt_chan #(
      .DLOG2(DATA_DEPTH_LOG2), .LLOG2(LEN_DEPTH_LOG2),
      .D_AFULL(DATA_AFULL_THR), .L_AFULL(LEN_AFULL_THR)
    ) u_chan (
      .clk_i, .rst_ni,
      .trg_acc_i  (trg_acc),
      .wr_i       (wr_en_i[c]),
      .din_i      (wr_data_i[c*WORD_W +: WORD_W]),
      .done_i     (done_i[c]),
      .released_i (released),
      .data_pop_i (data_pop[c]),
      .len_pop_i  (len_pop[c]),
      .data_head_o(data_head[c]),
      .len_head_o (len_head[c]),
      .len_empty_o(len_empty[c]),
      .st_o       (st[c]),
      .afull_o    (afull_o[c]),
      .ovf_o      (ovf_o[c]),
      .stat_o     (stat[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q         <= 1'b0;
      busy_release_o <= 1'b0;
    end else begin
      busy_release_o <= rel_fire;
      if (trg_acc)       pend_q <= 1'b1;
      else if (rel_fire) pend_q <= 1'b0;
    end
  end

  evt_rd_seq #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_rd (
    .clk_i, .rst_ni,
    .start_i    (rd_start_i),
    .len_empty_i(len_empty),
    .len_head_i (len_head),
    .data_head_i(data_head),
    .len_pop_o  (len_pop),
    .data_pop_o (data_pop),
    .rd_valid_o,
    .rd_data_o,
    .rd_ch_o,
    .rd_done_o
  );

  always_comb begin
    stat_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (stat_addr_i == STAT_BASE + 16'(c)) stat_data_o = stat[c];
    end
  end

  // R7/R8: release is a single-cycle pulse
  a_r7_release_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_release_o |=> !busy_release_o);

  a_r2_trg_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_i && !(&is_idle)) |=> !$rose(pend_q));

  if (REL_AFTER_DATA) begin : g_chk_after
    a_r8_release_after_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_release_o |-> $past(&is_wait));
  end

  a_r9_wait_leaves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_release_o && $past(is_wait[0])) |-> (st[0] == CH_IDLE));

endmodule

// File: tb/evt_buf_ctrl_tb_top.sv
module evt_buf_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // main instance: 3 channels, release after data
  logic        trg = 0, rd_start = 0;
  logic [2:0]  wr_en = '0, done = '0, usr_rel = 3'b111;
  logic [95:0] wr_data = '0;
  logic [15:0] stat_addr = 16'h7100;
  logic        busy_rel, rd_valid, rd_done;
  logic [2:0]  afull, ovf;
  logic [31:0] rd_data, stat_data;
  logic [1:0]  rd_ch;

  evt_buf_ctrl #(.NUM_CH(3), .DATA_DEPTH_LOG2(8), .LEN_DEPTH_LOG2(2),
                 .DATA_AFULL_THR(200), .LEN_AFULL_THR(3), .REL_AFTER_DATA(1'b1))
  dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trg_i(trg), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .done_i(done), .usr_rel_i(usr_rel), .rd_start_i(rd_start), .stat_addr_i(stat_addr),
    .busy_release_o(busy_rel), .afull_o(afull), .ovf_o(ovf), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .rd_ch_o(rd_ch), .rd_done_o(rd_done), .stat_data_o(stat_data)
  );

  // second instance: 2 channels, immediate release
  logic        trg2 = 0;
  logic [1:0]  wr2 = '0, done2 = '0, rel2 = '0;
  logic [15:0] stat_addr2 = 16'h7100;
  logic        busy2, rdv2, rdd2;
  logic [1:0]  af2, ov2;
  logic [31:0] rdata2, stat2;
  logic        rch2;

  evt_buf_ctrl #(.NUM_CH(2), .DATA_DEPTH_LOG2(8), .LEN_DEPTH_LOG2(2),
                 .DATA_AFULL_THR(200), .LEN_AFULL_THR(3), .REL_AFTER_DATA(1'b0))
  dut_imm_i (
    .clk_i(clk), .rst_ni(rst_n), .trg_i(trg2), .wr_en_i(wr2), .wr_data_i(64'h0),
    .done_i(done2), .usr_rel_i(rel2), .rd_start_i(1'b0), .stat_addr_i(stat_addr2),
    .busy_release_o(busy2), .afull_o(af2), .ovf_o(ov2), .rd_valid_o(rdv2),
    .rd_data_o(rdata2), .rd_ch_o(rch2), .rd_done_o(rdd2), .stat_data_o(stat2)
  );

  int n_chk = 0, n_bad = 0;
  logic [33:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected status word from the bit layout of R1..R12 (st: 0 idle, 1 write, 2 wait)
  function automatic logic [31:0] mk(int fill, bit emp, bit af, bit fu, bit ws, int st,
                                     bit le, bit la, bit lf, bit lw);
    return {4'b0, lw, lf, la, le, 1'b0, st == 2, st == 1, st == 0, ws, fu, af, emp, 16'(fill)};
  endfunction

  task automatic stat_of(input int c, output logic [31:0] v);
    stat_addr = 16'h7100 + 16'(c);
    #1 v = stat_data;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input int c, input logic [31:0] d, input bit fin);
    wr_en[c] = 1'b1;
    wr_data[c*32 +: 32] = d;
    done[c] = fin;
    exp_q.push_back({2'(c), d});
    @(negedge clk);
    wr_en[c] = 1'b0;
    done[c] = 1'b0;
  endtask

  task automatic readout(input string req);
    bit got = 0;
    @(negedge clk) rd_start = 1'b1;
    @(negedge clk) rd_start = 1'b0;
    for (int i = 0; i < 700 && !got; i++) begin
      if (rd_done) got = 1;
      else @(negedge clk);
    end
    #1;
    chk({req, " rd_done seen"}, 32'(got), 32'd1);
    chk({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  // monitor: compare readout against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected word actual=%h expected=none", {rd_ch, rd_data});
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        if ({rd_ch, rd_data} !== e) begin
          n_bad++;
          $display("FAIL R10 readout actual=%h expected=%h", {rd_ch, rd_data}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    stat_of(0, v); chk("R1 stat ch0", v, 32'h0111_0000);
    stat_of(2, v); chk("R1 stat ch2", v, 32'h0111_0000);
    chk("R1 outputs", {busy_rel, afull, ovf, rd_valid}, '0);
    // R11 decode
    stat_addr = 16'h7103; #1 chk("R11 beyond last ch", stat_data, 0);
    stat_addr = 16'h70FF; #1 chk("R11 below base", stat_data, 0);

    // R3 write while idle is ignored
    wr_en[0] = 1; wr_data[31:0] = 32'hDEAD; cyc(1); wr_en[0] = 0; cyc(1);
    stat_of(0, v); chk("R3 idle write ignored", v, 32'h0111_0000);

    // R2 trigger
    trg = 1; cyc(1); trg = 0;
    stat_of(0, v); chk("R2 writing after trigger", v, mk(0,1,0,0,0,1,1,0,0,0));

    // event 1: ch0 three words, ch1 empty, ch2 two words
    wr_en[0] = 1; wr_data[31:0] = 32'hA0; stat_of(0, v);
    chk("R3 write strobe bit19", v, mk(0,1,0,0,1,1,1,0,0,0));
    exp_q.push_back({2'd0, 32'hA0}); cyc(1); wr_en[0] = 0;
    put(0, 32'hA1, 0);
    put(0, 32'hA2, 1);
    done[1] = 1; cyc(1); done[1] = 0;
    stat_of(0, v); chk("R4 wait phase ch0", v, mk(3,0,0,0,0,2,0,0,0,0));
    chk("R8 no release while ch2 writing", busy_rel, 0);
    trg = 1; cyc(1); trg = 0;
    stat_of(0, v); chk("R2 trigger ignored when busy", v, mk(3,0,0,0,0,2,0,0,0,0));
    put(2, 32'hB0, 0);
    put(2, 32'hB1, 1);
    stat_of(2, v); chk("R4 count with last word", v, mk(2,0,0,0,0,2,0,0,0,0));
    chk("R8 release not yet", busy_rel, 0);
    cyc(1);
    chk("R8 release after all done", busy_rel, 1);
    stat_of(0, v); chk("R9 back to idle", v, mk(3,0,0,0,0,0,0,0,0,0));
    cyc(1);
    chk("R7 release one cycle", busy_rel, 0);
    readout("R10 event1");
    stat_of(1, v); chk("R10 ch1 length consumed", v, 32'h0111_0000);

    // R5/R6 fill to full and beyond on ch0
    trg = 1; cyc(1); trg = 0;
    for (int i = 0; i < 260; i++) begin
      wr_en[0] = 1; wr_data[31:0] = 32'h1000 + i;
      if (i < 256) exp_q.push_back({2'd0, 32'h1000 + i});
      cyc(1);
      if (i == 198) chk("R6 below threshold", afull[0], 0);
      if (i == 199) chk("R6 at threshold", afull[0], 1);
      if (i == 255) chk("R5 no overflow at depth", ovf[0], 0);
    end
    wr_en[0] = 0;
    chk("R5 overflow set", ovf[0], 1);
    stat_of(0, v); chk("R5 full status", v, mk(256,0,1,1,0,1,1,0,0,0));
    done = 3'b111; cyc(1); done = 0;
    cyc(2);
    readout("R5 length 256");
    chk("R5 overflow sticky", ovf[0], 1);
    stat_of(0, v); chk("R5 drained", v, 32'h0111_0000);

    // R12 length FIFO almost full / full with empty events
    for (int e = 0; e < 4; e++) begin
      trg = 1; cyc(1); trg = 0;
      done = 3'b111;
      if (e == 0) begin
        stat_of(1, v); chk("R4 length write strobe bit27", v, mk(0,1,0,0,0,1,1,0,0,1));
      end
      cyc(1); done = 0;
      cyc(3);
      if (e == 2) begin
        stat_of(1, v); chk("R12 length almost full", v, mk(0,1,0,0,0,0,0,1,0,0));
      end
    end
    stat_of(1, v); chk("R12 length full", v, mk(0,1,0,0,0,0,0,1,1,0));
    for (int e = 0; e < 4; e++) readout("R10 skip empty");
    stat_of(1, v); chk("R12 length drained", v, 32'h0111_0000);

    // R7/R9 immediate release instance
    trg2 = 1; cyc(1); trg2 = 0; cyc(1);
    chk("R7 no release without user", busy2, 0);
    rel2 = 2'b01; cyc(1);
    chk("R7 partial user release", busy2, 0);
    rel2 = 2'b11; cyc(1);
    chk("R7 immediate release", busy2, 1);
    stat_addr2 = 16'h7100; #1;
    chk("R7 still writing at release", stat2, mk(0,1,0,0,0,1,1,0,0,0));
    cyc(1);
    chk("R7 pulse ends", busy2, 0);
    done2 = 2'b11; cyc(1); done2 = 0; #1;
    chk("R4 wait phase imm", stat2, mk(0,1,0,0,0,2,0,0,0,0));
    cyc(1); #1;
    chk("R9 idle after late finish", stat2, mk(0,1,0,0,0,0,0,0,0,0));

    cyc(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule